// File: doc/BRIEF.md
# Add-Only Modular Multiplication Sequencer

This block computes the modular product (A·B) mod N with nothing but a single modular adder. After a start request it walks the multiplier B from its top bit downward. Leading zero bits cost no cycles. At the first set bit the running value is loaded with A. Each bit after that first doubles the running value modulo N, and if that bit is set, adds A modulo N as a separate step. Every step takes one clock.

The same sequencer also offers a modular negation, (N − A) mod N, which completes in one step. A caller presents the operands together with a start pulse, waits for the one-cycle done pulse, and then reads the result. The result stays unchanged until the caller issues another start. Operands must satisfy 0 ≤ A, B < N.

Top module: `addchain_modmul`

## Requirements
- R1: After a synchronous reset with rst_n low, busy is 0, done is 0 and result is 0.
- R2: With op = 0 (multiply), the result equals (A·B) mod N for any A, B < N.
- R3: With op = 0 and B = 0, the result is 0 and done rises on the first clock edge after the edge that accepted start, with no addition steps.
- R4: With op = 0 and B ≠ 0, let k be the index of the highest set bit of B and p the number of set bits. Done rises exactly k + p clock edges after the accepting edge, which is never more than 2·(W−1)+1.
- R5: Every value produced by a doubling or adding step is below N.
- R6: With op = 1 (negate), the result equals (N − A) mod N, which is 0 when A = 0. Done rises one edge after the accepting edge.
- R7: Done is a single-cycle pulse and is never high together with busy. Busy is high from the edge after start until done rises.
- R8: A start that arrives while busy is ignored. While the block is idle and start is low, the result holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 1 | 0 = modular multiply, 1 = modular negate |
| a | input | W | Operand A (< N) |
| b | input | W | Multiplier B (< N), ignored for negate |
| n | input | W | Modulus N |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Result, held until the next start |

## Verification
Assertions check several properties on every cycle. Each doubling or adding step stays below the modulus. Done lasts one cycle and never overlaps busy. Captured operands cannot change while busy. The result cannot move while the block is idle, and B = 0 finishes at once with zero. The bench's scenarios are needed for the rest. They show that the arithmetic is correct against an independently computed product, and that the exact latency follows the top-bit position and the number of set bits. They also show that negation of zero gives zero, and that a start injected in the middle of an operation leaves the answer intact.

// File: rtl/amm_pkg.sv
// Shared types for the add-only modular multiplication sequencer.
// Assumes nothing beyond a synthesizable enum encoding.
package amm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DBL,
        ST_ADD
    } amm_state_e;

    localparam logic OP_MUL = 1'b0;
    localparam logic OP_NEG = 1'b1;
endpackage

// File: rtl/amm_modadd.sv
// Combinational modular adder: sum = (x + y) mod n.
// Assumes x < n and y < n, so a single conditional subtraction suffices.
// The raw sum comes first, and a trial subtraction of n follows. The borrow
// of that subtraction picks which of the two goes out.
module amm_modadd #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] n,
    output logic [W-1:0] sum
);
    logic [W:0]   raw;
    logic [W+1:0] trial;
    logic         borrow;

    // Add, trial-subtract the modulus, keep whichever is in range.
    always_comb begin
        raw    = {1'b0, x} + {1'b0, y};
        trial  = {1'b0, raw} - {2'b00, n};
        borrow = trial[W+1];
        sum    = borrow ? raw[W-1:0] : trial[W-1:0];
    end
endmodule

// File: rtl/amm_lead_one.sv
// Leading-one finder: reports the index of the highest set bit of v.
// Assumes IW is wide enough to hold W-1. found is 0 when v is all zeros,
// and idx is then 0.
module amm_lead_one #(
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic [W-1:0]  v,
    output logic [IW-1:0] idx,
    output logic          found
);
    // Scan upward so the highest set bit wins.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (v[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/addchain_modmul.sv
// Add-only modular multiply / negate sequencer.
// Computes (a*b) mod n by a left-to-right scan of b. At the first set bit it
// loads a. Each later bit doubles mod n, then adds a mod n if that bit is set.
// Every step is one clock. Negate returns (n-a) mod n in one step.
// Assumes a, b < n. Operands are captured on the accepting edge.
module addchain_modmul #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] n,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    import amm_pkg::*;

    localparam int IW = (W > 1) ? $clog2(W) : 1;

    amm_state_e    state;
    logic          op_q;
    logic [W-1:0]  a_q, b_q, n_q, acc;
    logic [IW-1:0] idx;
    logic [IW-1:0] lead_idx;
    logic          lead_found;
    logic [W-1:0]  add_y, add_sum, neg_val;

    amm_lead_one #(.W(W), .IW(IW)) i_lead (
        .v     (b_q),
        .idx   (lead_idx),
        .found (lead_found)
    );

    // Second addend: a for the add step, the accumulator itself for doubling.
    assign add_y = (state == ST_ADD) ? a_q : acc;

    amm_modadd #(.W(W)) i_add (
        .x   (acc),
        .y   (add_y),
        .n   (n_q),
        .sum (add_sum)
    );

    // Additive inverse, with zero mapping to zero.
    assign neg_val = (a_q == '0) ? '0 : (n_q - a_q);

    assign busy   = (state != ST_IDLE);
    assign result = acc;

    // Sequencer: operand capture, scan and per-step accumulator update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= OP_MUL;
            a_q   <= '0;
            b_q   <= '0;
            n_q   <= '0;
            acc   <= '0;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_q  <= op;
                        a_q   <= a;
                        b_q   <= b;
                        n_q   <= n;
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (op_q == OP_NEG) begin
                        acc   <= neg_val;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (!lead_found) begin
                        acc   <= '0;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        acc <= a_q;
                        if (lead_idx == '0) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            idx   <= lead_idx - 1'b1;
                            state <= ST_DBL;
                        end
                    end
                end
                ST_DBL: begin
                    acc <= add_sum;
                    if (b_q[idx]) begin
                        state <= ST_ADD;
                    end else if (idx == '0) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        idx <= idx - 1'b1;
                    end
                end
                ST_ADD: begin
                    acc <= add_sum;
                    if (idx == '0) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        idx   <= idx - 1'b1;
                        state <= ST_DBL;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: every doubling or adding step lands below the modulus.
    p_step_below_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DBL || state == ST_ADD) |=> (acc < n_q));

    // R7: done lasts one cycle and never overlaps busy.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: captured operands are frozen while busy; idle result holds.
    p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(n_q) && $stable(a_q) && $stable(b_q)));
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

    // R3: zero multiplier finishes at once with zero.
    p_zero_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && op_q == OP_MUL && b_q == '0) |=> (done && result == '0));
endmodule

// File: tb/test_addchain_modmul.sv
// Bench for addchain_modmul: directed corners plus seeded random operands.
module test_addchain_modmul;
    localparam int W        = 16;
    localparam int CLK_PER  = 10;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op = 1'b0;
    logic [W-1:0] a = '0, b = '0, n = '0;
    logic         busy, done;
    logic [W-1:0] result;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    addchain_modmul #(.W(W)) i_addchain_modmul (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .a(a), .b(b), .n(n), .busy(busy), .done(done), .result(result)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_mul(input longint x, input longint y, input longint m);
        return (x * y) % m;
    endfunction

    function automatic longint exp_neg(input longint x, input longint m);
        return (x == 0) ? 0 : (m - x);
    endfunction

    function automatic int exp_lat(input logic [W-1:0] y);
        int k = 0;
        int p = 0;
        if (y == '0) return 1;
        for (int i = 0; i < W; i++) begin
            if (y[i]) begin
                k = i;
                p++;
            end
        end
        return k + p;
    endfunction

    // Run one operation, optionally poking start mid-flight with junk operands.
    task automatic run_op(input logic o, input logic [W-1:0] av, input logic [W-1:0] bv,
                          input logic [W-1:0] nv, input bit poke, input string tag);
        int     lat = 0;
        longint expv;
        int     el;
        logic [W-1:0] held;
        expv = (o == 1'b0) ? exp_mul(av, bv, nv) : exp_neg(av, nv);
        el   = (o == 1'b0) ? exp_lat(bv) : 1;
        @(negedge clk);
        op = o; a = av; b = bv; n = nv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 100) begin
            if (poke && lat == 1 && busy) begin
                start = 1'b1; a = ~av; b = ~bv; op = ~o;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        if (o == 1'b0) begin
            check({tag, " R2 product"}, result, expv);
            check({tag, " R4 latency"}, lat, el);
        end else begin
            check({tag, " R6 negate"}, result, expv);
            check({tag, " R6 latency"}, lat, 1);
        end
        check({tag, " R7 busy low with done"}, busy, 0);
        held = result;
        @(negedge clk);
        check({tag, " R7 done single pulse"}, done, 0);
        check({tag, " R8 result held idle"}, result, held);
    endtask

    initial begin
        logic [W-1:0] rn, ra, rb;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 result", result, 0);
        rst_n = 1'b1;

        // R3: zero multiplier.
        run_op(1'b0, 16'd1234, 16'd0, 16'd40000, 1'b0, "R3 b=0");
        check("R3 zero result", result, 0);
        run_op(1'b0, 16'd7, 16'd1, 16'd11, 1'b0, "b=1");
        run_op(1'b0, 16'd65534, 16'd65534, 16'd65535, 1'b0, "max");
        run_op(1'b0, 16'd65520, 16'h8001, 16'd65521, 1'b0, "R4 top bit");
        run_op(1'b0, 16'd3, 16'd5, 16'd7, 1'b0, "small");
        run_op(1'b0, 16'd0, 16'd0, 16'd1, 1'b0, "n=1");
        // R6: negate corners.
        run_op(1'b1, 16'd0, 16'd0, 16'd97, 1'b0, "R6 neg zero");
        run_op(1'b1, 16'd96, 16'd0, 16'd97, 1'b0, "R6 neg max");
        // R8: start poked while busy.
        run_op(1'b0, 16'd12345, 16'h7FFF, 16'd54321, 1'b1, "R8 poke");

        for (int t = 0; t < 200; t++) begin
            rn = W'($urandom_range(1, (1 << W) - 1));
            ra = W'($urandom % rn);
            rb = W'($urandom % rn);
            run_op(($urandom % 5) == 0, ra, rb, rn, (t % 7) == 0, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule